// File: doc/BRIEF.md
# Flash Bulk Transfer Engine

This block sits between a host register port and a serial flash and moves bulk data through a 32-bit word FIFO. To read, the host loads a flash word address and issues a read command with a word count. The engine fetches that many consecutive words into the FIFO and holds a busy flag until they are all in. The host then drains them one by one from a single data-port offset. To write, the host waits until the reported free space equals the full FIFO capacity, then pushes words through the same data port. The engine streams them out to consecutive flash addresses.

Flash ownership is negotiated with a request/grant pair. A register bit drives the request, a status bit shows the returned grant, and the engine starts no flash access unless the grant is present. A control write with the read-mode bit clear flushes the FIFO, aborts any remaining read and puts the engine back into write mode.

Host offsets are 0 = control, 1 = flash address, 2 = data port and 3 = ownership.

The control word has these fields:
- bits [6:0] hold the read count on writes and the words still to fetch on reads.
- bit 8 is read mode.
- bit 9 is busy (read only).
- bits [22:16] hold the FIFO free space in words (read only).
- bit 24 is the sticky overflow flag (read only).

Top module: `flash_bulk_xfer`

## Requirements
- R1: After reset, control reads 0x0040_0000: free space 64 in bits [22:16], busy (bit 9), read mode (bit 8) and overflow (bit 24) all clear. Address and ownership registers read 0.
- R2: A control write with bit 8 set and a count in bits [6:0] from 1 to 64 is accepted when the engine is idle, the FIFO is empty and the grant is present. Busy reads 1 from the next cycle until that many words, taken from consecutive flash addresses starting at the address pointer, are in the FIFO. Free space then reads 64 minus the count.
- R3: In read mode, each read of offset 2 returns the FIFO head and pops it, so words arrive in flash address order.
- R4: A read command is ignored, with busy, free space and mode unchanged, in any of these cases: busy is set, the count is 0 or above 64, the grant is absent, or the FIFO is not empty.
- R5: A control write with bit 8 clear does all of the following: flushes the FIFO, cancels the rest of a read, discards any read word still in flight, clears overflow and selects write mode.
- R6: In write mode, words written to offset 2 are written to flash at consecutive addresses from the pointer while the grant is present. Free space then returns to 64.
- R7: Byte lanes whose strobe bit is clear in a data-port write are stored as 0xFF.
- R8: A data-port write in write mode while the FIFO is full is dropped and sets overflow (bit 24). Overflow stays set until an R5 clear.
- R9: A data-port write in read mode is dropped and leaves free space unchanged. A data-port read in write mode returns 0 and pops nothing.
- R10: Ownership bit 0 drives `mux_req`, and bit 1 reads back `mux_gnt`. No flash request starts while the grant is low.
- R11: A flash request keeps its address, direction and write data stable until acknowledged.
- R12: Offset 1 reads the flash pointer. The pointer is loaded by a host write and advances by one on each acknowledged flash access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (pops on data port) |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 32 | Host write data |
| host_wstrb | input | 4 | Byte strobes for data-port writes |
| host_rdata | output | 32 | Register read data, same cycle |
| mux_req | output | 1 | Host asks for flash ownership |
| mux_gnt | input | 1 | Flash ownership granted to host side |
| fl_req | output | 1 | Flash access request, held until ack |
| fl_we | output | 1 | 1 = write, 0 = read |
| fl_addr | output | 24 | Flash word address |
| fl_wdata | output | 32 | Flash write word |
| fl_rdata | input | 32 | Flash read word, valid with ack |
| fl_ack | input | 1 | One-cycle access completion |

## Verification
The assertions rely on three assumptions about the flash side: `fl_ack` is a single-cycle pulse, it arrives only while `fl_req` is high, and `mux_gnt` changes only in response to `mux_req`. The bench's flash model acknowledges each access once, a fixed number of cycles after the request rises, and its arbiter follows the request after a short delay. Host accesses keep to the documented sequence, except where a rule under test deliberately breaks it: commands while busy, out-of-range counts, and data-port traffic in the wrong mode.

// File: rtl/fbx_pkg.sv
package fbx_pkg;
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_ADDR = 2'd1,
      REG_DATA = 2'd2,
      REG_OWN  = 2'd3
   } fbx_reg_e;

   localparam int CTL_MODE_BIT = 8;
   localparam int CTL_BUSY_BIT = 9;
   localparam int CTL_FREE_LSB = 16;
   localparam int CTL_OVF_BIT  = 24;
endpackage

// File: rtl/fbx_pad.sv
module fbx_pad #(
   parameter int         DW  = 32,
   parameter logic [7:0] PAD = 8'hFF
) (
   input  logic [DW-1:0]   din,
   input  logic [DW/8-1:0] strb,
   output logic [DW-1:0]   dout
);
   localparam int LANES = DW / 8;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign dout[l*8 +: 8] = strb[l] ? din[l*8 +: 8] : PAD;
   end
endmodule

// File: rtl/fbx_fifo.sv
module fbx_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  logic [DW-1:0]              wdata,
   input  logic                       pop,
   output logic [DW-1:0]              head,
   output logic [$clog2(DEPTH):0]     count
);
   localparam int AW = $clog2(DEPTH);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [AW:0]   cnt_q;
   logic          full, empty, do_push, do_pop;

   assign full    = cnt_q == (AW+1)'(DEPTH);
   assign empty   = cnt_q == '0;
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;

   always_ff @(posedge clk) begin
      if (do_push) mem[wp_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign head  = empty ? '0 : mem[rp_q];
   assign count = cnt_q;
endmodule

// File: rtl/fbx_seq.sv
module fbx_seq #(
   parameter int DW    = 32,
   parameter int FA_W  = 24,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gnt,
   input  logic             wr_mode,
   input  logic             ptr_load,
   input  logic [FA_W-1:0]  ptr_val,
   input  logic             start,
   input  logic [CNT_W-1:0] start_cnt,
   input  logic             abort,
   input  logic             fifo_empty,
   input  logic             fifo_full,
   input  logic [DW-1:0]    fifo_head,
   output logic             busy,
   output logic [CNT_W-1:0] left,
   output logic             eng_push,
   output logic             eng_pop,
   output logic             fl_req,
   output logic             fl_we,
   output logic [FA_W-1:0]  fl_addr,
   output logic [DW-1:0]    fl_wdata,
   input  logic             fl_ack
);
   logic             act_q, we_q;
   logic [CNT_W-1:0] left_q;
   logic [FA_W-1:0]  ptr_q;
   logic [DW-1:0]    wdat_q;
   logic             launch_rd, launch_wr, done;

   assign launch_rd = !act_q && left_q != '0 && !fifo_full && gnt && !abort;
   assign launch_wr = !act_q && left_q == '0 && wr_mode && !fifo_empty && gnt && !abort;
   assign done      = act_q && fl_ack;
   assign eng_push  = done && !we_q && !wr_mode;
   assign eng_pop   = launch_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         we_q   <= 1'b0;
         left_q <= '0;
         ptr_q  <= '0;
         wdat_q <= '0;
      end else begin
         if (launch_rd) begin
            act_q <= 1'b1;
            we_q  <= 1'b0;
         end else if (launch_wr) begin
            act_q  <= 1'b1;
            we_q   <= 1'b1;
            wdat_q <= fifo_head;
         end else if (done) begin
            act_q <= 1'b0;
         end

         if (abort)         left_q <= '0;
         else if (start)    left_q <= start_cnt;
         else if (eng_push) left_q <= left_q - 1'b1;

         if (ptr_load)  ptr_q <= ptr_val;
         else if (done) ptr_q <= ptr_q + 1'b1;
      end
   end

   assign busy     = left_q != '0 || (act_q && !we_q);
   assign left     = left_q;
   assign fl_req   = act_q;
   assign fl_we    = we_q;
   assign fl_addr  = ptr_q;
   assign fl_wdata = wdat_q;
endmodule

// File: rtl/flash_bulk_xfer.sv
module flash_bulk_xfer
   import fbx_pkg::*;
#(
   parameter int         DW    = 32,
   parameter int         FA_W  = 24,
   parameter int         DEPTH = 64,
   parameter logic [7:0] PAD   = 8'hFF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            host_wr,
   input  logic            host_rd,
   input  logic [1:0]      host_addr,
   input  logic [31:0]     host_wdata,
   input  logic [3:0]      host_wstrb,
   output logic [31:0]     host_rdata,
   output logic            mux_req,
   input  logic            mux_gnt,
   output logic            fl_req,
   output logic            fl_we,
   output logic [23:0]     fl_addr,
   output logic [31:0]     fl_wdata,
   input  logic [31:0]     fl_rdata,
   input  logic            fl_ack
);
   localparam int CNT_W = $clog2(DEPTH) + 1;

   if (DW != 32 || FA_W != 24) begin : g_bad_width
      $error("flash_bulk_xfer: port widths are fixed at DW=32, FA_W=24");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("flash_bulk_xfer: DEPTH must be a power of two >= 2");
   end
   if (CNT_W > 8) begin : g_bad_cnt
      $error("flash_bulk_xfer: count field must fit below the mode bit");
   end

   logic             wr_mode_q, ovf_q, own_q;
   logic [CNT_W-1:0] fcount, free_w, left_w, cmd_cnt;
   logic             full_w, empty_w, busy_w;
   logic             ctrl_wr, rd_cmd, rd_go, clr, data_wr, host_push, ovf_set, host_pop;
   logic             eng_push, eng_pop;
   logic [DW-1:0]    head_w, pad_w, fifo_in;
   logic [CNT_W-1:0] depth_c;

   assign depth_c   = CNT_W'(DEPTH);
   assign free_w    = depth_c - fcount;
   assign full_w    = fcount == depth_c;
   assign empty_w   = fcount == '0;
   assign cmd_cnt   = host_wdata[CNT_W-1:0];
   assign ctrl_wr   = host_wr && host_addr == REG_CTRL;
   assign rd_cmd    = ctrl_wr && host_wdata[CTL_MODE_BIT];
   assign clr       = ctrl_wr && !host_wdata[CTL_MODE_BIT];
   assign rd_go     = rd_cmd && !busy_w && mux_gnt && empty_w &&
                      cmd_cnt != '0 && cmd_cnt <= depth_c;
   assign data_wr   = host_wr && host_addr == REG_DATA && wr_mode_q;
   assign host_push = data_wr && !full_w;
   assign ovf_set   = data_wr && full_w;
   assign host_pop  = host_rd && host_addr == REG_DATA && !wr_mode_q && !empty_w;
   assign fifo_in   = host_push ? pad_w : fl_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_mode_q <= 1'b1;
         ovf_q     <= 1'b0;
         own_q     <= 1'b0;
      end else begin
         if (clr)        wr_mode_q <= 1'b1;
         else if (rd_go) wr_mode_q <= 1'b0;
         if (clr)          ovf_q <= 1'b0;
         else if (ovf_set) ovf_q <= 1'b1;
         if (host_wr && host_addr == REG_OWN) own_q <= host_wdata[0];
      end
   end

   fbx_pad #(.DW(DW), .PAD(PAD)) pad_i (
      .din (host_wdata),
      .strb(host_wstrb),
      .dout(pad_w)
   );

   fbx_fifo #(.DW(DW), .DEPTH(DEPTH)) fifo_i (
      .clk  (clk),
      .rst_n(rst_n),
      .flush(clr),
      .push (host_push || eng_push),
      .wdata(fifo_in),
      .pop  (host_pop || eng_pop),
      .head (head_w),
      .count(fcount)
   );

   fbx_seq #(.DW(DW), .FA_W(FA_W), .CNT_W(CNT_W)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .gnt       (mux_gnt),
      .wr_mode   (wr_mode_q),
      .ptr_load  (host_wr && host_addr == REG_ADDR),
      .ptr_val   (host_wdata[FA_W-1:0]),
      .start     (rd_go),
      .start_cnt (cmd_cnt),
      .abort     (clr),
      .fifo_empty(empty_w),
      .fifo_full (full_w),
      .fifo_head (head_w),
      .busy      (busy_w),
      .left      (left_w),
      .eng_push  (eng_push),
      .eng_pop   (eng_pop),
      .fl_req    (fl_req),
      .fl_we     (fl_we),
      .fl_addr   (fl_addr),
      .fl_wdata  (fl_wdata),
      .fl_ack    (fl_ack)
   );

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         REG_CTRL: begin
            host_rdata[CNT_W-1:0]             = left_w;
            host_rdata[CTL_MODE_BIT]          = !wr_mode_q;
            host_rdata[CTL_BUSY_BIT]          = busy_w;
            host_rdata[CTL_FREE_LSB +: CNT_W] = free_w;
            host_rdata[CTL_OVF_BIT]           = ovf_q;
         end
         REG_ADDR: host_rdata[FA_W-1:0] = fl_addr;
         REG_DATA: host_rdata = wr_mode_q ? '0 : head_w;
         default:  host_rdata[1:0] = {mux_gnt, own_q};
      endcase
   end

   assign mux_req = own_q;
endmodule

// File: rtl/fbx_chk.sv
module fbx_chk #(
   parameter int FA_W = 24
) (
   input logic            clk,
   input logic            rst_n,
   input logic            host_wr,
   input logic [1:0]      host_addr,
   input logic [31:0]     host_wdata,
   input logic            mux_gnt,
   input logic            fl_req,
   input logic            fl_we,
   input logic [FA_W-1:0] fl_addr,
   input logic [31:0]     fl_wdata,
   input logic            fl_ack,
   input logic            busy,
   input logic            wr_mode,
   input logic            ovf,
   input logic            full
);
   logic clr_w;
   assign clr_w = host_wr && host_addr == 2'd0 && !host_wdata[8];

   // R11
   fl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req && !fl_ack |=> fl_req && $stable(fl_addr) && $stable(fl_we) && $stable(fl_wdata));

   // R10
   no_grant_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_req) |-> $past(mux_gnt));

   // R8
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_addr == 2'd2 && wr_mode && full && !clr_w |=> ovf);

   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf && !clr_w |=> ovf);

   // R2
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(fl_ack) || $past(clr_w));

   // R12
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req && fl_ack && !(host_wr && host_addr == 2'd1) |=> fl_addr == FA_W'($past(fl_addr) + 1'b1));
endmodule

bind flash_bulk_xfer fbx_chk #(.FA_W(FA_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_wr   (host_wr),
   .host_addr (host_addr),
   .host_wdata(host_wdata),
   .mux_gnt   (mux_gnt),
   .fl_req    (fl_req),
   .fl_we     (fl_we),
   .fl_addr   (fl_addr),
   .fl_wdata  (fl_wdata),
   .fl_ack    (fl_ack),
   .busy      (busy_w),
   .wr_mode   (wr_mode_q),
   .ovf       (ovf_q),
   .full      (full_w)
);

// File: tb/flash_bulk_xfer_tb_top.sv
module flash_bulk_xfer_tb_top;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [1:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [3:0]  host_wstrb = 4'hF;
   logic [31:0] host_rdata;
   logic        mux_req, mux_gnt = 1'b0;
   logic        fl_req, fl_we, fl_ack = 1'b0;
   logic [23:0] fl_addr;
   logic [31:0] fl_wdata, fl_rdata = '0;

   int n_chk = 0, n_fail = 0, req_seen = 0;
   bit finished = 0;
   logic [31:0] mem [256];
   logic [31:0] exp_q[$], got_q[$];
   logic [2:0]  gnt_sh = '0;
   int lat = 0;

   always #5 clk = ~clk;

   flash_bulk_xfer dut_i (.*);

   function automatic logic [31:0] pat(int a);
      return {8'hA5, 8'(a), 8'(~a), 8'(a * 3)};
   endfunction

   initial for (int i = 0; i < 256; i++) mem[i] = pat(i);

   // flash model
   always @(negedge clk) begin
      if (!rst_n) begin
         fl_ack = 1'b0; lat = 0;
      end else if (fl_ack) begin
         fl_ack = 1'b0;
      end else if (fl_req) begin
         req_seen++;
         lat++;
         if (lat == LAT) begin
            lat = 0;
            fl_ack = 1'b1;
            if (fl_we) mem[fl_addr[7:0]] = fl_wdata;
            else fl_rdata = mem[fl_addr[7:0]];
         end
      end
   end

   // ownership arbiter: grant follows request after a few cycles
   always @(negedge clk) begin
      gnt_sh  = {gnt_sh[1:0], mux_req};
      mux_gnt = gnt_sh[2] & mux_req;
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      while (got_q.size() > 0) begin
         logic [31:0] g;
         g = got_q.pop_front();
         if (exp_q.size() == 0) check("R3 (unexpected word)", g, 32'hx);
         else check("R3 data order", g, exp_q.pop_front());
      end
   end

   task automatic reg_wr(logic [1:0] a, logic [31:0] d, logic [3:0] s = 4'hF);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d; host_wstrb = s;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic reg_rd(logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic poll(logic [1:0] a, logic [31:0] mask, logic [31:0] val, string req);
      logic [31:0] d;
      for (int i = 0; i < 2000; i++) begin
         reg_rd(a, d);
         if ((d & mask) == val) return;
      end
      check({req, " poll timeout"}, d & mask, val);
   endtask

   task automatic drain(int n);
      logic [31:0] d;
      for (int i = 0; i < n; i++) begin
         reg_rd(2'd2, d);
         got_q.push_back(d);
      end
   endtask

   task automatic expect_read(int a, int n);
      for (int i = 0; i < n; i++) exp_q.push_back(pat(a + i));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int snap;
      logic [31:0] wv [6];
      repeat (4) @(posedge clk);
      rst_n = 1'b1;

      // R1 reset state
      reg_rd(2'd0, d); check("R1 ctrl", d, 32'h0040_0000);
      reg_rd(2'd3, d); check("R1 own", d, 32'h0);
      reg_rd(2'd1, d); check("R1 addr", d, 32'h0);

      // R4 read without grant ignored, R10 no access without grant
      reg_wr(2'd1, 32'h10);
      reg_wr(2'd0, 32'h104);
      repeat (10) @(negedge clk);
      reg_rd(2'd0, d); check("R4 no-grant cmd ignored", d, 32'h0040_0000);
      check("R10 no flash access without grant", req_seen, 0);

      // R10 ownership handshake
      reg_wr(2'd3, 32'h1);
      check("R10 mux_req", {31'b0, mux_req}, 32'h1);
      poll(2'd3, 32'h3, 32'h3, "R10 grant status");

      // R2/R3 five-word read
      reg_wr(2'd1, 32'h10);
      reg_wr(2'd0, 32'h105);
      reg_rd(2'd0, d); check("R2 busy raised", (d >> 9) & 1, 32'h1);
      poll(2'd0, 32'h200, 32'h0, "R2 busy");
      reg_rd(2'd0, d); check("R2 free after burst", d, 32'h003B_0100);
      reg_rd(2'd1, d); check("R12 pointer after read", d, 32'h15);
      reg_wr(2'd2, 32'hDEAD_BEEF);
      reg_rd(2'd0, d); check("R9 data write in read mode dropped", d, 32'h003B_0100);
      expect_read(16'h10, 5);
      drain(5);
      reg_rd(2'd0, d); check("R3 fifo empty after drain", d, 32'h0040_0100);
      reg_wr(2'd0, 32'h0);
      reg_rd(2'd0, d); check("R5 clear to idle", d, 32'h0040_0000);

      // R4 command while busy ignored
      reg_wr(2'd1, 32'h20);
      reg_wr(2'd0, 32'h108);
      reg_wr(2'd0, 32'h103);
      poll(2'd0, 32'h200, 32'h0, "R4 busy");
      reg_rd(2'd0, d); check("R4 busy cmd ignored", d, 32'h0038_0100);
      expect_read(16'h20, 8);
      drain(8);
      reg_wr(2'd0, 32'h0);

      // R4 out-of-range counts
      reg_wr(2'd0, 32'h100);
      reg_rd(2'd0, d); check("R4 count 0 ignored", d, 32'h0040_0000);
      reg_wr(2'd0, 32'h141);
      reg_rd(2'd0, d); check("R4 count 65 ignored", d, 32'h0040_0000);

      // R2 full-depth read
      reg_wr(2'd1, 32'h40);
      reg_wr(2'd0, 32'h140);
      poll(2'd0, 32'h200, 32'h0, "R2 busy full");
      reg_rd(2'd0, d); check("R2 fifo full after 64", d, 32'h0000_0100);
      expect_read(16'h40, 64);
      drain(64);
      reg_wr(2'd0, 32'h0);

      // R4 fifo not empty
      reg_wr(2'd1, 32'h60);
      reg_wr(2'd0, 32'h102);
      poll(2'd0, 32'h200, 32'h0, "R4 busy");
      reg_wr(2'd0, 32'h102);
      reg_rd(2'd0, d); check("R4 non-empty cmd ignored", d, 32'h003E_0100);
      reg_wr(2'd0, 32'h0);

      // R5 abort mid-read
      reg_wr(2'd1, 32'h70);
      reg_wr(2'd0, 32'h110);
      repeat (12) @(negedge clk);
      reg_wr(2'd0, 32'h0);
      repeat (10) @(negedge clk);
      reg_rd(2'd0, d); check("R5 abort flush", d, 32'h0040_0000);

      // R6/R7 write path
      reg_wr(2'd1, 32'h80);
      poll(2'd0, 32'h007F_0000, 32'h0040_0000, "R6 free full");
      for (int i = 0; i < 6; i++) begin
         wv[i] = 32'hC0DE_0000 | i;
         reg_wr(2'd2, wv[i], (i == 5) ? 4'h3 : 4'hF);
      end
      wv[5] = 32'hFFFF_0005;
      poll(2'd0, 32'h007F_0000, 32'h0040_0000, "R6 drained");
      repeat (10) @(negedge clk);
      reg_rd(2'd1, d); check("R12 pointer after writes", d, 32'h86);
      check("R7 padded word in flash", mem[8'h85], 32'hFFFF_0005);
      reg_wr(2'd1, 32'h80);
      reg_wr(2'd0, 32'h106);
      poll(2'd0, 32'h200, 32'h0, "R6 readback busy");
      for (int i = 0; i < 6; i++) exp_q.push_back(wv[i]);
      drain(6);
      reg_wr(2'd0, 32'h0);

      // R8 overflow with ownership released
      reg_wr(2'd3, 32'h0);
      poll(2'd3, 32'h3, 32'h0, "R10 release");
      snap = req_seen;
      for (int i = 0; i < 65; i++) reg_wr(2'd2, 32'h1000 + i);
      reg_rd(2'd0, d); check("R8 overflow sticky", d, 32'h0100_0000);
      reg_rd(2'd2, d); check("R9 data read in write mode", d, 32'h0);
      reg_rd(2'd0, d); check("R9 no pop in write mode", d, 32'h0100_0000);
      check("R10 no access after release", req_seen, snap);
      reg_wr(2'd0, 32'h0);
      reg_rd(2'd0, d); check("R8 overflow cleared", d, 32'h0040_0000);

      repeat (4) @(negedge clk);
      check("R3 scoreboard empty", exp_q.size(), 0);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule